// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Buffered Compare

This block is a timer whose counter climbs from zero to a period limit and then falls back to zero. A compare channel turns that triangle into a waveform whose pulses stay centred in the period. The counter advances only on a tick, a one-cycle enable that a prescaler derives from the system clock. The prescaler divides by 1, 8, 64, 256 or 1024, or it holds the timer stopped. There is no second clock domain.

The period limit comes from one of two places. It can come from a dedicated limit register, which leaves the compare value free to set the duty cycle. It can also come from the compare register itself, so that a toggling output gives a square wave. Writes to the limit, the compare value and the limit source land in buffers. The counter takes them up only when it leaves zero, so a period or duty change made while the timer runs never produces a torn or off-centre pulse. A sticky match flag records every compare match until software clears it.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: On each tick the count moves by one. It rises from 0 to the active limit, then falls back to 0. The limit and zero are each held for exactly one tick, so one period lasts 2 × limit ticks. With a limit of 0 the count stays at 0.
- R2: The prescaler select code sets the tick rate. Code 0 stops the timer, and codes 6 and 7 also stop it. Codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 cycles. A configuration write restarts the division, so the first tick after a write of code N comes after N system cycles.
- R3: With output mode code 2, a compare match reached while the count is rising drives the pin high. A match reached while the count is falling drives it low. The output level changes only on a match.
- R4: Output mode code 3 gives the opposite levels to mode 2: low on a rising match and high on a falling match.
- R5: In modes 2 and 3, a compare value of 0 forces the non-inverted level low at every match. A compare value equal to the active limit forces it high. In mode 2 the pin therefore stays constantly low or constantly high.
- R6: When the limit source bit is 1, the active compare value is the period limit. In that case output mode code 1 toggles the pin at each match, giving a 50 % duty square wave that lasts two counter periods.
- R7: Writes to the limit, the compare value and the limit source go into buffers. The active copies load only on the tick taken while the count is 0, and that tick already uses the new values.
- R8: The match flag sets on a tick at which the count equals the active compare value. It stays set until a write to the flag clear input, and a match in the same cycle as that write wins.
- R9: With output mode code 0, the pin reads low whatever the compare matches. The match flag still operates.
- R10: Synchronous reset clears the count, the buffers, the active values, the configuration, the flag and the pin. After reset the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| top_wr | input | 1 | Write strobe for the limit buffer |
| top_wdata | input | CNT_W | Limit value to buffer |
| cmp_wr | input | 1 | Write strobe for the compare buffer |
| cmp_wdata | input | CNT_W | Compare value to buffer |
| cfg_wr | input | 1 | Write strobe for the configuration |
| cfg_mode | input | 2 | Output mode: 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| cfg_top_from_cmp | input | 1 | Limit source: 0 dedicated register, 1 compare value (buffered) |
| cfg_psel | input | 3 | Prescaler select code |
| flag_clr | input | 1 | Write-one clear of the match flag |
| count | output | CNT_W | Current counter value |
| pwm_out | output | 1 | Waveform pin level |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
On every cycle the assertions check that the count never passes the active limit, that it moves by exactly one per tick and holds between ticks, and that the active values change only on the tick at zero. They also check that the output level moves only on a match, that a match always leaves the flag set, and that the flag stays set until a clear. Only the bench scenarios show the actual shape of the waveform. That covers the centred pulse placement, the inverted, constant-low, constant-high and toggle cases, the moment a buffered write takes effect, and the exact cycle of the first tick under each prescaler code.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

    localparam int PSC_W = 10;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_SET_UP = 2'd2,
        OM_CLR_UP = 2'd3
    } out_mode_e;

    typedef enum logic [2:0] {
        PS_STOP    = 3'd0,
        PS_DIV1    = 3'd1,
        PS_DIV8    = 3'd2,
        PS_DIV64   = 3'd3,
        PS_DIV256  = 3'd4,
        PS_DIV1024 = 3'd5,
        PS_RSV6    = 3'd6,
        PS_RSV7    = 3'd7
    } psel_e;

    typedef struct packed {
        out_mode_e mode;
        psel_e     psel;
    } cfg_t;

    // terminal value of the divider for a select code (N - 1)
    function automatic logic [PSC_W-1:0] psc_limit(input psel_e s);
        case (s)
            PS_DIV8:    return PSC_W'(7);
            PS_DIV64:   return PSC_W'(63);
            PS_DIV256:  return PSC_W'(255);
            PS_DIV1024: return PSC_W'(1023);
            default:    return '0;
        endcase
    endfunction

    function automatic logic psc_running(input psel_e s);
        return (s == PS_DIV1) || (s == PS_DIV8) || (s == PS_DIV64) ||
               (s == PS_DIV256) || (s == PS_DIV1024);
    endfunction

endpackage

// File: rtl/pwm_dual_presc.sv
module pwm_dual_presc
    import pwm_dual_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  psel_e psel,
    output logic  tick
);
    logic [PSC_W-1:0] div_q;
    logic             run;

    assign run  = psc_running(psel);
    assign tick = run && (div_q == psc_limit(psel));

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick) div_q <= '0;
        else                                div_q <= div_q + 1'b1;
    end

    // R2: at divide-by-8 two ticks are never adjacent
    assert_div8_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && psel == PS_DIV8 && !restart) |=> (!tick || psel != PS_DIV8));

endmodule

// File: rtl/pwm_dual_updown.sv
module pwm_dual_updown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             top_wr,
    input  logic [CNT_W-1:0] top_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             src_wr,
    input  logic             src_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_now,
    output logic [CNT_W-1:0] top_now,
    output logic             move_up
);
    logic [CNT_W-1:0] top_buf, cmp_buf, top_act, cmp_act, cnt_q;
    logic             src_buf, src_act, up_q;
    logic             load, src_now;
    logic [CNT_W-1:0] top_reg_now;

    // buffered values take effect on the tick that leaves zero
    assign load        = tick && (cnt_q == '0);
    assign cmp_now     = load ? cmp_buf : cmp_act;
    assign src_now     = load ? src_buf : src_act;
    assign top_reg_now = load ? top_buf : top_act;
    assign top_now     = src_now ? cmp_now : top_reg_now;
    assign move_up     = (cnt_q == '0) || (up_q && (cnt_q < top_now));
    assign count       = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_buf <= '0;
            cmp_buf <= '0;
            src_buf <= 1'b0;
        end else begin
            if (top_wr) top_buf <= top_wdata;
            if (cmp_wr) cmp_buf <= cmp_wdata;
            if (src_wr) src_buf <= src_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_act <= '0;
            cmp_act <= '0;
            src_act <= 1'b0;
        end else if (load) begin
            top_act <= top_buf;
            cmp_act <= cmp_buf;
            src_act <= src_buf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (tick && (top_now != '0)) begin
            cnt_q <= move_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
            up_q  <= move_up;
        end
    end

    // R1: the count never passes the active limit
    assert_count_within_top_R1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= (src_act ? cmp_act : top_act));

    // R1: each tick with a non-zero limit moves the count by exactly one
    assert_step_one_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && top_now != '0) |=>
            (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));

    // R2: without a tick the count holds
    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    // R7: active copies change only on the tick at zero
    assert_buffer_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(cmp_act) && $stable(top_act) && $stable(src_act)));

endmodule

// File: rtl/pwm_dual_cmp.sv
module pwm_dual_cmp
    import pwm_dual_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_now,
    input  logic [CNT_W-1:0] top_now,
    input  logic             move_up,
    input  out_mode_e        mode,
    input  logic             flag_clr,
    output logic             pwm_out,
    output logic             flag
);
    logic match, lvl, oc_q, flag_q;

    assign match = tick && (count == cmp_now);
    // non-inverted level for this match, extremes pinned
    assign lvl = (cmp_now == '0)      ? 1'b0 :
                 (cmp_now == top_now) ? 1'b1 : move_up;

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_q <= 1'b0;
        end else if (match) begin
            case (mode)
                OM_TOGGLE: oc_q <= ~oc_q;
                OM_SET_UP: oc_q <= lvl;
                OM_CLR_UP: oc_q <= ~lvl;
                default:   oc_q <= 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (match)    flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign flag    = flag_q;
    assign pwm_out = (mode == OM_OFF) ? 1'b0 : oc_q;

    // R3: the output level moves only on a compare match
    assert_level_only_on_match_R3: assert property (@(posedge clk) disable iff (rst)
        !match |=> $stable(oc_q));

    // R8: a match always leaves the flag set
    assert_flag_on_match_R8: assert property (@(posedge clk) disable iff (rst)
        match |=> flag_q);

    // R8: the flag is sticky until cleared
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: rtl/pwm_dual_slope_timer.sv
module pwm_dual_slope_timer
    import pwm_dual_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             top_wr,
    input  logic [CNT_W-1:0] top_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_top_from_cmp,
    input  logic [2:0]       cfg_psel,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             pwm_out,
    output logic             match_flag
);
    cfg_t             cfg_q;
    logic             tick, move_up;
    logic [CNT_W-1:0] cmp_now, top_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode <= OM_OFF;
            cfg_q.psel <= PS_STOP;
        end else if (cfg_wr) begin
            cfg_q.mode <= out_mode_e'(cfg_mode);
            cfg_q.psel <= psel_e'(cfg_psel);
        end
    end

    pwm_dual_presc u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_wr),
        .psel    (cfg_q.psel),
        .tick    (tick)
    );

    pwm_dual_updown #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .top_wr    (top_wr),
        .top_wdata (top_wdata),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .src_wr    (cfg_wr),
        .src_wdata (cfg_top_from_cmp),
        .count     (count),
        .cmp_now   (cmp_now),
        .top_now   (top_now),
        .move_up   (move_up)
    );

    pwm_dual_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .count    (count),
        .cmp_now  (cmp_now),
        .top_now  (top_now),
        .move_up  (move_up),
        .mode     (cfg_q.mode),
        .flag_clr (flag_clr),
        .pwm_out  (pwm_out),
        .flag     (match_flag)
    );

endmodule

// File: tb/pwm_dual_slope_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_dual_slope_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       top_wr = 1'b0, cmp_wr = 1'b0, cfg_wr = 1'b0, flag_clr = 1'b0;
    logic [7:0] top_wdata = '0, cmp_wdata = '0;
    logic [1:0] cfg_mode = '0;
    logic       cfg_top_from_cmp = 1'b0;
    logic [2:0] cfg_psel = '0;
    logic [7:0] count;
    logic       pwm_out, match_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm_dual_slope_timer #(.CNT_W(8)) dut_i (
        .clk(clk), .rst(rst),
        .top_wr(top_wr), .top_wdata(top_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_top_from_cmp(cfg_top_from_cmp), .cfg_psel(cfg_psel),
        .flag_clr(flag_clr),
        .count(count), .pwm_out(pwm_out), .match_flag(match_flag)
    );

    // limit 4, compare 2, mode 2, divide by 1: {count, pin} after edges 2..17
    localparam logic [8:0] EXP1 [16] = '{
        {8'd1,1'b0}, {8'd2,1'b0}, {8'd3,1'b1}, {8'd4,1'b1},
        {8'd3,1'b1}, {8'd2,1'b1}, {8'd1,1'b0}, {8'd0,1'b0},
        {8'd1,1'b0}, {8'd2,1'b0}, {8'd3,1'b1}, {8'd4,1'b1},
        {8'd3,1'b1}, {8'd2,1'b1}, {8'd1,1'b0}, {8'd0,1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
    endtask

    // writes land on the next edge (edge 1 of a scenario)
    task automatic setup(input int t, input int c, input int m, input bit src, input int ps);
        top_wdata = 8'(t); cmp_wdata = 8'(c);
        cfg_mode = 2'(m); cfg_top_from_cmp = src; cfg_psel = 3'(ps);
        top_wr = 1'b1; cmp_wr = 1'b1; cfg_wr = 1'b1;
        @(posedge clk);
        #2 top_wr = 1'b0; cmp_wr = 1'b0; cfg_wr = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int highs;
        do_reset();
        // R10 reset state
        chk("R10 count", count, 0);
        chk("R10 pwm", pwm_out, 0);
        chk("R10 flag", match_flag, 0);
        // R2 stopped after reset
        step(5);
        chk("R2 stopped", count, 0);

        // R1 / R3 table walk
        setup(4, 2, 2, 1'b0, 1);
        for (int i = 0; i < 16; i++) begin
            step(1);
            chk("R1 count", count, int'(EXP1[i][8:1]));
            chk("R3 pwm", pwm_out, int'(EXP1[i][0]));
        end
        // R8 flag clear then re-set on next match
        chk("R8 flag set", match_flag, 1);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk("R8 flag cleared", match_flag, 0);
        step(2);
        chk("R8 flag re-set", match_flag, 1);

        // R10 synchronous reset mid-run
        do_reset();
        chk("R10 count mid", count, 0);
        chk("R10 flag mid", match_flag, 0);

        // R4 inverted
        setup(4, 2, 3, 1'b0, 1);
        step(7);
        chk("R4 falling match", pwm_out, 1);
        step(4);
        chk("R4 rising match", pwm_out, 0);

        // R5 compare at zero stays low
        do_reset();
        setup(4, 0, 2, 1'b0, 1);
        highs = 0;
        for (int i = 0; i < 16; i++) begin step(1); highs += int'(pwm_out); end
        chk("R5 low", highs, 0);

        // R5 compare at limit stays high
        do_reset();
        setup(4, 4, 2, 1'b0, 1);
        step(4);
        chk("R5 before match", pwm_out, 0);
        highs = 0;
        for (int i = 0; i < 16; i++) begin step(1); highs += int'(pwm_out); end
        chk("R5 high", highs, 16);

        // R6 toggle with compare as limit
        do_reset();
        setup(9, 3, 1, 1'b1, 1);
        step(3);
        chk("R6 limit from cmp", count, 3);
        step(1);
        chk("R6 toggle 1", pwm_out, 1);
        step(5);
        chk("R6 hold", pwm_out, 1);
        step(1);
        chk("R6 toggle 2", pwm_out, 0);
        step(6);
        chk("R6 toggle 3", pwm_out, 1);

        // R7 buffered update mid-period
        do_reset();
        setup(4, 2, 2, 1'b0, 1);
        step(3);
        top_wdata = 8'd6; cmp_wdata = 8'd1; top_wr = 1'b1; cmp_wr = 1'b1;
        @(posedge clk);
        #2 top_wr = 1'b0; cmp_wr = 1'b0;
        chk("R7 count", count, 4);
        step(1);
        chk("R7 old limit", count, 3);
        step(2);
        chk("R7 old compare", pwm_out, 0);
        step(3);
        chk("R7 new compare", pwm_out, 1);
        step(4);
        chk("R7 new limit", count, 6);
        step(1);
        chk("R7 turn", count, 5);

        // R2 divide by 8
        do_reset();
        setup(2, 1, 2, 1'b0, 2);
        step(7);
        chk("R2 div8 wait", count, 0);
        step(1);
        chk("R2 div8 tick1", count, 1);
        step(7);
        chk("R2 div8 hold", count, 1);
        step(1);
        chk("R2 div8 tick2", count, 2);

        // R9 mode off, flag still works
        do_reset();
        setup(4, 2, 0, 1'b0, 1);
        step(2);
        chk("R9 flag early", match_flag, 0);
        step(1);
        chk("R9 flag set", match_flag, 1);
        highs = 0;
        for (int i = 0; i < 16; i++) begin step(1); highs += int'(pwm_out); end
        chk("R9 pin low", highs, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule